// File: doc/BRIEF.md
# Bit-Enabled Power Control Register Bank

This block is a small bank of 32-bit control registers that sit between a simple register port and a power sequencer. Each written word carries its own update mask. The upper sixteen bits of the word pick which of the lower sixteen bits change. Every other bit keeps its value. Several software agents can therefore flip individual control bits without a read-modify-write sequence.

The bank holds five registers:

- Two adjacent registers form a 32-bit power-switch request vector. A 1 in this vector asks for a domain to be powered off.
- Two adjacent registers form a 32-bit bus idle-request vector.
- One register holds the clock force-ungate bits.

The stored values drive the sequencer outputs directly. Reads return the stored low half after one cycle.

Top module: `pwr_mask_regbank`

## Requirements
- R1: A write to a mapped register sets bit n (0..15) to wData[n] when wData[n+16] is 1. This applies to both values: a 0 clears the bit and a 1 sets it.
- R2: During a write, every bit whose enable wData[n+16] is 0 keeps its previous value.
- R3: A write whose enable half wData[31:16] is all zero leaves the register unchanged.
- R4: pwrOffReq carries the stored power-switch bits unchanged. A 1 requests power off and a 0 requests power on.
- R5: The power-switch vector is split across two registers. Byte offset 0x00 holds pwrOffReq[15:0] and offset 0x04 holds pwrOffReq[31:16]. The idle-request vector is split the same way: offset 0x08 holds idleReq[15:0] and offset 0x0C holds idleReq[31:16].
- R6: The clock-ungate register sits at offset 0x10 and drives clkUngate[15:0]. A single masked write can set or clear a field of several adjacent bits.
- R7: A read request raises rdValid exactly one cycle later. rdData[15:0] then holds the stored value and rdData[31:16] holds 0.
- R8: After reset every register holds its parameter reset value. The default is 0, meaning power requested on, no idle request and no clocks force-ungated.
- R9: An access to any other offset is unmapped. This includes offsets with address bits [1:0] not zero and offsets at 0x14 and above. Such a read returns 0, and such a write changes no register.
- R10: A write to one register leaves every other register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regValid | input | 1 | Access request this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Byte offset |
| regWdata | input | 32 | Enable mask [31:16] and data [15:0] |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| pwrOffReq | output | 32 | Power-switch request vector, 1 = off |
| idleReq | output | 32 | Bus idle-request vector |
| clkUngate | output | 16 | Clock force-ungate bits |

## Verification
The assertions check four properties on every cycle:
- Bits whose enable is clear never change during a write.
- A register that is not addressed never changes.
- A read is answered exactly one cycle later, with a zero upper half.
- Unmapped reads return zero and misaligned writes select nothing.

Only the bench scenarios can show that each bit takes the value actually written. They also show that the four split registers land in the correct halves of the output vectors, that a multi-bit ungate field changes in one write, and that the reset values appear at the outputs.

// File: rtl/pwr_mask_regbank_pkg.sv
package pwr_mask_regbank_pkg;
  localparam int NUM_REGS = 5;
  localparam int IDX_W    = $clog2(NUM_REGS);
  localparam int HALF_W   = 16;

  // Register index order: 0/1 power switch, 2/3 idle request, 4 clock ungate
  localparam int IDX_PWR_LO  = 0;
  localparam int IDX_PWR_HI  = 1;
  localparam int IDX_IDLE_LO = 2;
  localparam int IDX_IDLE_HI = 3;
  localparam int IDX_CLK     = 4;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic                rdEn;
    logic                rdHit;
    logic [IDX_W-1:0]    rdIdx;
  } regStrobe_t;
endpackage

// File: rtl/pwr_mask_regbank_ctrl.sv
module pwr_mask_regbank_ctrl
  import pwr_mask_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  output regStrobe_t        strb
);
  logic [NUM_REGS-1:0] hitVec;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
      assign hitVec[i] = (regAddr == ADDR_W'(i * 4));
    end
  endgenerate

  always_comb begin
    strb.wrSel = hitVec & {NUM_REGS{regValid & regWrite}};
    strb.rdEn  = regValid & ~regWrite;
    strb.rdHit = |hitVec;
    strb.rdIdx = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hitVec[i]) strb.rdIdx = IDX_W'(i);
    end
  end

  // R9: misaligned offsets never select a register
  p_misaligned_nosel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regValid && regWrite && regAddr[1:0] != 2'b00) |-> (strb.wrSel == '0));

  // R10: at most one register selected per write
  p_single_sel_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrSel));
endmodule

// File: rtl/pwr_mask_regbank_dp.sv
module pwr_mask_regbank_dp
  import pwr_mask_regbank_pkg::*;
#(
  parameter logic [NUM_REGS*HALF_W-1:0] RST_VALS = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  regStrobe_t  strb,
  input  logic [31:0] wData,
  output logic        rdValid,
  output logic [31:0] rdData,
  output logic [31:0] pwrOffReq,
  output logic [31:0] idleReq,
  output logic [15:0] clkUngate
);
  logic [HALF_W-1:0] regQ [NUM_REGS];
  logic [HALF_W-1:0] wrEn;
  logic [HALF_W-1:0] wrVal;

  assign wrEn  = wData[31:16];
  assign wrVal = wData[15:0];

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regQ[i] <= RST_VALS[i*HALF_W +: HALF_W];
        else if (strb.wrSel[i]) regQ[i] <= (regQ[i] & ~wrEn) | (wrVal & wrEn);
      end

      // R2: bits with a clear enable keep their value across a write
      p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrSel[i] |=> (((regQ[i] ^ $past(regQ[i])) & ~$past(wData[31:16])) == '0));

      // R10: an unaddressed register does not move
      p_other_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
        !strb.wrSel[i] |=> $stable(regQ[i]));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.rdEn;
      if (strb.rdEn) rdData <= strb.rdHit ? {16'h0, regQ[strb.rdIdx]} : 32'h0;
    end
  end

  assign pwrOffReq = {regQ[IDX_PWR_HI], regQ[IDX_PWR_LO]};
  assign idleReq   = {regQ[IDX_IDLE_HI], regQ[IDX_IDLE_LO]};
  assign clkUngate = regQ[IDX_CLK];

  // R7: read answered one cycle later
  p_rd_latency_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEn |=> rdValid);
  // R7: upper half of read data is zero
  p_rd_upper_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (rdData[31:16] == 16'h0));
  // R9: unmapped reads return zero
  p_unmapped_rd_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.rdHit) |=> (rdData == 32'h0));
endmodule

// File: rtl/pwr_mask_regbank.sv
module pwr_mask_regbank
  import pwr_mask_regbank_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [NUM_REGS*HALF_W-1:0] RST_VALS = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic              rdValid,
  output logic [31:0]       rdData,
  output logic [31:0]       pwrOffReq,
  output logic [31:0]       idleReq,
  output logic [15:0]       clkUngate
);
  regStrobe_t strb;

  pwr_mask_regbank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .strb(strb)
  );

  pwr_mask_regbank_dp #(.RST_VALS(RST_VALS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wData(regWdata),
    .rdValid(rdValid), .rdData(rdData), .pwrOffReq(pwrOffReq),
    .idleReq(idleReq), .clkUngate(clkUngate)
  );
endmodule

// File: tb/sim_pwr_mask_regbank.sv
module sim_pwr_mask_regbank;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regValid = 1'b0, regWrite = 1'b0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic rdValid;
  logic [31:0] rdData, pwrOffReq, idleReq;
  logic [15:0] clkUngate;

  int errors = 0, checks = 0;
  logic [15:0] mdl [5];
  logic [31:0] expQ [$];
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mask_regbank u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    if (a[1:0] == 2'b00 && a < 8'h14)
      mdl[a>>2] = (mdl[a>>2] & ~d[31:16]) | (d[15:0] & d[31:16]);
    @(negedge clk);
    regValid = 0; regWrite = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    regValid = 1; regWrite = 0; regAddr = a;
    expQ.push_back((a[1:0] == 2'b00 && a < 8'h14) ? {16'h0, mdl[a>>2]} : 32'h0);
    @(negedge clk);
    regValid = 0;
  endtask

  task automatic chkOuts(input string req);
    chk({req, " pwr"}, pwrOffReq, {mdl[1], mdl[0]});
    chk({req, " idle"}, idleReq, {mdl[3], mdl[2]});
    chk({req, " clk"}, {16'h0, clkUngate}, {16'h0, mdl[4]});
  endtask

  // Monitor / scoreboard (R7): rdValid must match one queued read
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected rdValid actual=1 expected=0");
      end else begin
        chk("R7 read data", rdData, expQ.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chkOuts("R8 reset");
    for (int i = 0; i < 5; i++) rd(8'(i * 4));
    // R1/R4: set bit0 (power off), clear bit2
    wr(8'h00, 32'h0005_0001);
    chk("R4 pwr bit0 off", {31'h0, pwrOffReq[0]}, 32'h1);
    chkOuts("R1 set/clear");
    // R3: zero enable
    wr(8'h00, 32'h0000_FFFF);
    chkOuts("R3 no enable");
    // R2: only bit1 enabled
    wr(8'h00, 32'h0002_FFFF);
    chkOuts("R2 masked");
    // R5: upper power half and idle halves
    wr(8'h04, 32'h8001_FFFF);
    chk("R5 pwr hi", pwrOffReq, 32'h8001_0003);
    wr(8'h08, 32'h00F0_00A0);
    wr(8'h0C, 32'h0100_0100);
    chk("R5 idle", idleReq, 32'h0100_00A0);
    // R6: three-bit ungate field in one write, then clear
    wr(8'h10, 32'h7000_7000);
    chk("R6 clk group", {16'h0, clkUngate}, 32'h0000_7000);
    wr(8'h10, 32'h3000_0000);
    chk("R6 clk clear", {16'h0, clkUngate}, 32'h0000_4000);
    // R1: clear with data 0
    wr(8'h00, 32'h0001_0000);
    chkOuts("R1 clear");
    // R9: unmapped accesses, R10: nothing else moves
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    chkOuts("R9 R10 unmapped write");
    rd(8'h14); rd(8'h02); rd(8'hFC);
    for (int i = 0; i < 5; i++) rd(8'(i * 4));
    // back-to-back reads
    rd(8'h04); rd(8'h10);
    repeat (3) @(negedge clk);
    chk("R7 drained", 32'(expQ.size()), 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule